// File: doc/BRIEF.md
# Real-mode indirect MMIO access bridge

This bridge lets early start-up firmware reach a 32-bit memory-mapped register space from legacy x86 I/O ports, before PCI configuration is available. Firmware writes four single-byte address ports, in any order, to build a 32-bit target address. When every byte has been written, an internal written mask makes the bridge armed. The next ordinary I/O data access, whether a read or a write, then goes to the MMIO port at that address instead of the legacy register file.

A redirected access is single-shot. When it completes, the written mask clears, so each further MMIO access needs all four bytes written again. The host side is a held-request I/O bus that completes on `io_ready`. The device side is a single-beat MMIO request that stays raised until a response-valid pulse arrives. Accesses that are not redirected pass straight through to the legacy port.

Top module: `rmio_bridge`

## Requirements
- R1: Ports 0x3D0, 0x3D1, 0x3D2 and 0x3D3 hold target address bits 7:0, 15:8, 23:16 and 31:24. A write stores `io_wdata[7:0]`. A read returns the stored byte in `io_rdata[7:0]` with the upper bits zero. Either access completes in the cycle it is presented.
- R2: While a redirected access is pending, `mm_addr` equals the assembled 32-bit address and does not change.
- R3: The bridge arms only after all four address ports have been written, in any order. With any byte missing, a data access goes to the legacy port.
- R4: Once armed, the next access to a port outside 0x3D0 to 0x3D3 raises `mm_req` and leaves `leg_req` low.
- R5: A redirected read holds `io_ready` low until `mm_rsp_valid` is seen. It then returns `mm_rdata` on `io_rdata`.
- R6: A redirected write drives `mm_wr`=1, `mm_wdata`=`io_wdata` and `mm_be`=4'hF.
- R7: After a redirected access completes, the bridge is disarmed, and the next data access goes to the legacy port.
- R8: A repeated write to an address port replaces that byte. Reads of the address ports leave the armed state unchanged.
- R9: A synchronous active-low reset clears all address bytes and the written mask.
- R10: A data access that is not redirected drives `leg_req` with the host's write flag, port and data. It returns `leg_rdata` and completes on `leg_ready`. With no request, no request leaves the block and `io_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | Host I/O access request, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port number |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, valid with io_ready |
| io_ready | output | 1 | Access completes this cycle |
| leg_req | output | 1 | Request to legacy register file |
| leg_wr | output | 1 | Legacy write flag |
| leg_port | output | 16 | Legacy port number |
| leg_wdata | output | 32 | Legacy write data |
| leg_rdata | input | 32 | Legacy read data |
| leg_ready | input | 1 | Legacy access done |
| mm_req | output | 1 | MMIO single-beat request, held until response |
| mm_wr | output | 1 | MMIO write flag |
| mm_addr | output | 32 | MMIO target address |
| mm_wdata | output | 32 | MMIO write data |
| mm_be | output | 4 | MMIO byte enables |
| mm_rdata | input | 32 | MMIO read data |
| mm_rsp_valid | input | 1 | MMIO response valid |

## Verification
The bench writes the address bytes out of order and tries a data access while one byte is still missing. A design that armed early would redirect that access. It rewrites a byte after the bridge is armed and reads address ports while armed, which catches a stale byte or a read that wrongly disarms the bridge. It follows each redirected access with a plain one, which catches a bridge that stays armed. It also delays the MMIO response by several cycles, so a design that completed the host read early would return wrong data.

// File: rtl/rmio_pkg.sv
// Package: shared types for the real-mode indirect MMIO bridge.
// Assumes the four address ports sit on an aligned group of port numbers.
package rmio_pkg;

    // Where one host access is steered.
    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_ADDR   = 2'd1,
        RT_LEGACY = 2'd2,
        RT_MMIO   = 2'd3
    } route_t;

endpackage

// File: rtl/rmio_addr_bank.sv
// Module: rmio_addr_bank
// Holds the target address one byte per address port. Assumes sel indexes
// the byte lane and that at most one write arrives per cycle.
module rmio_addr_bank #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [7:0]        wbyte,
    output logic [DATA_W-1:0] addr,
    output logic [7:0]        rd_byte
);

    logic [7:0] bytes_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Store or replace one address byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[g] <= '0;
            else if (wr_en && sel == SEL_W'(g))
                bytes_q[g] <= wbyte;
        end
        assign addr[g*8 +: 8] = bytes_q[g];
    end

    // Read back the selected byte.
    assign rd_byte = bytes_q[sel];

endmodule

// File: rtl/rmio_arm_track.sv
// Module: rmio_arm_track
// Tracks which address bytes have been written since the last redirected
// access. Assumes clear and wr_en never occur in the same cycle.
module rmio_arm_track #(
    parameter int NBYTES = 4,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic              clear,
    output logic [NBYTES-1:0] mask,
    output logic              armed
);

    logic [NBYTES-1:0] mask_q;

    // Set the written bit of the lane, or drop every bit after a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (clear)
            mask_q <= '0;
        else if (wr_en)
            mask_q[sel] <= 1'b1;
    end

    assign mask  = mask_q;
    assign armed = &mask_q;

endmodule

// File: rtl/rmio_router.sv
// Module: rmio_router
// Decides, combinationally, where the current host access goes.
// Assumes BASE_PORT is aligned to the number of address bytes.
module rmio_router
    import rmio_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter int          NBYTES    = 4,
    parameter logic [15:0] BASE_PORT = 16'h03D0,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic              io_req,
    input  logic [PORT_W-1:0] io_port,
    input  logic              armed,
    output route_t            route,
    output logic [SEL_W-1:0]  sel
);

    logic is_addr;

    // Match the aligned group of address ports.
    always_comb begin
        is_addr = (io_port[PORT_W-1:SEL_W] == BASE_PORT[PORT_W-1:SEL_W]);
        sel     = io_port[SEL_W-1:0];
    end

    // Pick the route for this access.
    always_comb begin
        if (!io_req)
            route = RT_NONE;
        else if (is_addr)
            route = RT_ADDR;
        else if (armed)
            route = RT_MMIO;
        else
            route = RT_LEGACY;
    end

endmodule

// File: rtl/rmio_bridge.sv
// Module: rmio_bridge (top)
// Lets host I/O accesses build a 32-bit address through four byte ports and
// then redirects the next data access to the MMIO port once. Assumes the host
// holds its request until io_ready, and that the MMIO side holds nothing
// beyond one response pulse per request.
module rmio_bridge
    import rmio_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter int          DATA_W    = 32,
    parameter logic [15:0] BASE_PORT = 16'h03D0,
    localparam int NBYTES = DATA_W / 8,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_ready,
    output logic              leg_req,
    output logic              leg_wr,
    output logic [PORT_W-1:0] leg_port,
    output logic [DATA_W-1:0] leg_wdata,
    input  logic [DATA_W-1:0] leg_rdata,
    input  logic              leg_ready,
    output logic              mm_req,
    output logic              mm_wr,
    output logic [DATA_W-1:0] mm_addr,
    output logic [DATA_W-1:0] mm_wdata,
    output logic [NBYTES-1:0] mm_be,
    input  logic [DATA_W-1:0] mm_rdata,
    input  logic              mm_rsp_valid
);

    route_t            route;
    logic [SEL_W-1:0]  sel;
    logic              armed;
    logic [NBYTES-1:0] mask;
    logic              addr_wr;
    logic              mm_done;
    logic [7:0]        rd_byte;
    logic [DATA_W-1:0] tgt_addr;

    rmio_router #(
        .PORT_W(PORT_W), .NBYTES(NBYTES), .BASE_PORT(BASE_PORT)
    ) u_router (
        .io_req(io_req), .io_port(io_port), .armed(armed),
        .route(route), .sel(sel)
    );

    rmio_addr_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(addr_wr), .sel(sel),
        .wbyte(io_wdata[7:0]), .addr(tgt_addr), .rd_byte(rd_byte)
    );

    rmio_arm_track #(.NBYTES(NBYTES)) u_arm (
        .clk(clk), .rst_n(rst_n), .wr_en(addr_wr), .sel(sel),
        .clear(mm_done), .mask(mask), .armed(armed)
    );

    // Address writes and redirect completion events.
    always_comb begin
        addr_wr = (route == RT_ADDR) && io_wr;
        mm_done = (route == RT_MMIO) && mm_rsp_valid;
    end

    // Device-side requests toward legacy and MMIO.
    always_comb begin
        leg_req   = (route == RT_LEGACY);
        leg_wr    = io_wr;
        leg_port  = io_port;
        leg_wdata = io_wdata;
        mm_req    = (route == RT_MMIO);
        mm_wr     = io_wr;
        mm_addr   = tgt_addr;
        mm_wdata  = io_wdata;
        mm_be     = '1;
    end

    // Host completion and read data by route.
    always_comb begin
        unique case (route)
            RT_ADDR: begin
                io_ready = 1'b1;
                io_rdata = {{(DATA_W-8){1'b0}}, rd_byte};
            end
            RT_LEGACY: begin
                io_ready = leg_ready;
                io_rdata = leg_rdata;
            end
            RT_MMIO: begin
                io_ready = mm_rsp_valid;
                io_rdata = mm_rdata;
            end
            default: begin
                io_ready = 1'b0;
                io_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/rmio_bridge_chk.sv
// Module: rmio_bridge_chk
// Protocol checks for rmio_bridge, bound onto every instance.
module rmio_bridge_chk #(
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_req,
    input logic              io_ready,
    input logic              leg_req,
    input logic              mm_req,
    input logic              mm_rsp_valid,
    input logic [31:0]       mm_addr,
    input logic              armed,
    input logic [NBYTES-1:0] mask
);

    // R4
    mm_leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_req |-> !leg_req);

    // R4
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_req |-> armed);

    // R5
    wait_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && !mm_rsp_valid) |-> !io_ready);

    // R7
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && mm_rsp_valid) |=> !armed);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && $past(mm_req) && !$past(mm_rsp_valid)) |-> $stable(mm_addr));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req |-> (!mm_req && !leg_req && !io_ready));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '0));

endmodule

bind rmio_bridge rmio_bridge_chk #(.NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_ready(io_ready),
    .leg_req(leg_req), .mm_req(mm_req), .mm_rsp_valid(mm_rsp_valid),
    .mm_addr(mm_addr), .armed(armed), .mask(mask)
);

// File: tb/rmio_bridge_tb_top.sv
module rmio_bridge_tb_top;

    localparam int MM_DLY = 2;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_port = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_ready;
    logic        leg_req, leg_wr;
    logic [15:0] leg_port;
    logic [31:0] leg_wdata, leg_rdata;
    logic        leg_ready;
    logic        mm_req, mm_wr;
    logic [31:0] mm_addr, mm_wdata, mm_rdata;
    logic [3:0]  mm_be;
    logic        mm_rsp_valid = 1'b0;
    int          dly_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    rmio_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_ready(io_ready), .leg_req(leg_req), .leg_wr(leg_wr),
        .leg_port(leg_port), .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
        .leg_ready(leg_ready), .mm_req(mm_req), .mm_wr(mm_wr),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_be(mm_be),
        .mm_rdata(mm_rdata), .mm_rsp_valid(mm_rsp_valid)
    );

    // Legacy model: always ready, data tagged by port.
    assign leg_ready = 1'b1;
    assign leg_rdata = 32'h1E6A_0000 | {16'h0, leg_port};
    // MMIO model: read data is the inverted address, response after MM_DLY.
    assign mm_rdata  = ~mm_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mm_rsp_valid <= 1'b0;
            dly_cnt      <= 0;
        end else if (mm_req && !mm_rsp_valid) begin
            if (dly_cnt == MM_DLY) begin
                mm_rsp_valid <= 1'b1;
                dly_cnt      <= 0;
            end else begin
                dly_cnt <= dly_cnt + 1;
            end
        end else begin
            mm_rsp_valid <= 1'b0;
            dly_cnt      <= 0;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Kind seen: 1 = address port, 2 = legacy, 3 = MMIO.
    task automatic io_access(input bit wr, input logic [15:0] port,
                             input logic [31:0] wd, output logic [31:0] rd,
                             output logic [1:0] kind, output int waits,
                             output logic [31:0] c_addr, output logic [31:0] c_wd,
                             output logic [3:0] c_be, output logic c_wr);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_port = port; io_wdata = wd;
        #1;
        kind  = mm_req ? 2'd3 : (leg_req ? 2'd2 : 2'd1);
        waits = 0;
        while (!io_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = io_rdata; c_addr = mm_addr; c_wd = mm_wdata; c_be = mm_be;
        c_wr = mm_wr;
        @(posedge clk); #1;
        io_req = 1'b0;
    endtask

    // {wr, kind, port, wdata, expected rdata, expected mm_addr}
    localparam logic [114:0] TBL [NV] = '{
        {1'b1, 2'd1, 16'h03D2, 32'h0000_00AB, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D0, 32'h0000_0034, 32'h0, 32'h0},
        {1'b0, 2'd2, 16'h03C0, 32'h0, 32'h1E6A_03C0, 32'h0},
        {1'b1, 2'd1, 16'h03D3, 32'h0000_0012, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D1, 32'hFFFF_FF56, 32'h0, 32'h0},
        {1'b0, 2'd1, 16'h03D1, 32'h0, 32'h0000_0056, 32'h0},
        {1'b0, 2'd3, 16'h03C5, 32'h0, ~32'h12AB_5634, 32'h12AB_5634},
        {1'b0, 2'd2, 16'h03C5, 32'h0, 32'h1E6A_03C5, 32'h0},
        {1'b1, 2'd1, 16'h03D0, 32'h0000_0001, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D1, 32'h0000_0002, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D2, 32'h0000_0003, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D3, 32'h0000_0004, 32'h0, 32'h0},
        {1'b1, 2'd1, 16'h03D0, 32'h0000_00FF, 32'h0, 32'h0},
        {1'b1, 2'd3, 16'h03CE, 32'hCAFE_F00D, 32'h0, 32'h0403_02FF},
        {1'b1, 2'd2, 16'h03CE, 32'h0000_0011, 32'h0, 32'h0}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, ca, cw;
        logic [1:0]  kd;
        logic [3:0]  cb;
        logic        cwr;
        int          wt;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 / R10: reset state, nothing requested.
        check(!io_ready && !mm_req && !leg_req, "R10 idle after reset",
              {29'b0, io_ready, mm_req, leg_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [114:0] e;
            e = TBL[i];
            io_access(e[114], e[111:96], e[95:64], rd, kd, wt, ca, cw, cb, cwr);
            case (e[113:112])
                2'd1: begin
                    check(kd == 2'd1, "R1 route addr port", {30'b0, kd}, 32'd1);
                    if (!e[114]) check(rd == e[63:32], "R1 addr byte read", rd, e[63:32]);
                end
                2'd2: begin
                    check(kd == 2'd2, "R3/R7/R10 route legacy", {30'b0, kd}, 32'd2);
                    if (!e[114]) check(rd == e[63:32], "R10 legacy read", rd, e[63:32]);
                end
                default: begin
                    check(kd == 2'd3, "R4 route mmio", {30'b0, kd}, 32'd3);
                    check(ca == e[31:0], "R2 mmio address", ca, e[31:0]);
                    if (e[114]) begin
                        check(cw == e[95:64] && cb == 4'hF && cwr,
                              "R6 mmio write data/enables", cw, e[95:64]);
                    end else begin
                        check(rd == e[63:32], "R5 mmio read data", rd, e[63:32]);
                        check(wt >= MM_DLY, "R5 read held in wait", wt, MM_DLY);
                    end
                end
            endcase
        end

        // R8: reading address ports while armed keeps the bridge armed.
        io_access(1'b1, 16'h03D3, 32'h77, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b1, 16'h03D1, 32'h66, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b1, 16'h03D2, 32'h55, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b1, 16'h03D0, 32'h44, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b0, 16'h03D2, 32'h0, rd, kd, wt, ca, cw, cb, cwr);
        check(rd == 32'h55, "R8 byte read while armed", rd, 32'h55);
        io_access(1'b0, 16'h03D3, 32'h0, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b0, 16'h0300, 32'h0, rd, kd, wt, ca, cw, cb, cwr);
        check(kd == 2'd3, "R8 still armed after reads", {30'b0, kd}, 32'd3);
        check(ca == 32'h7755_6644, "R2 address after rewrite", ca, 32'h7755_6644);

        // R9: partial write, then reset clears bytes and mask.
        io_access(1'b1, 16'h03D0, 32'h9A, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b1, 16'h03D1, 32'h9B, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b1, 16'h03D2, 32'h9C, rd, kd, wt, ca, cw, cb, cwr);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 4; p++) begin
            io_access(1'b0, 16'h03D0 + 16'(p), 32'h0, rd, kd, wt, ca, cw, cb, cwr);
            check(rd == 32'h0, "R9 byte cleared by reset", rd, 32'h0);
        end
        io_access(1'b1, 16'h03D3, 32'h9D, rd, kd, wt, ca, cw, cb, cwr);
        io_access(1'b0, 16'h03C8, 32'h0, rd, kd, wt, ca, cw, cb, cwr);
        check(kd == 2'd2, "R9 mask cleared by reset", {30'b0, kd}, 32'd2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule